// File: doc/BRIEF.md
# PLL Divider and Mode Control Register Bank

This block holds the configuration of one phase-locked loop in four 32-bit words on a simple register bus. Three of the words use a masked-write scheme: the upper halfword of the write data is a per-bit enable for the lower halfword. Software can therefore change one field, or one bit, without reading the word first. The word that holds the fraction takes an ordinary full write. The same word also returns a read-only lock flag, which comes from the analog macro through a synchronizer.

Every stored field drives a dedicated output toward the PLL: the feedback divider, the reference divider, the two post-dividers, the 24-bit fraction, the work mode and the integer-mode select. Reads are combinational. The bus presents a word address, a write strobe and write data. Read data for the addressed word appears in the same cycle. A write takes effect at the next rising clock edge.

Word addresses are byte-offset bits 3:2, so word k sits at byte offset 4*k. The bus is a plain register port with no valid/ready handshake, because every access completes in one cycle and is never stalled.

Top module: `pll_cfg_bank`

## Requirements
- R1: After reset every stored field is zero, the work mode reads as slow (encoding 0), and the lock flag reads 0.
- R2: On a write to word 0, 1 or 3, lower bit n takes write-data bit n only when write-data bit n+16 is 1. Otherwise bit n keeps its value.
- R3: Word 0 (byte offset 0x00) holds the 12-bit feedback divider in bits 11:0, driven on `cfg_fbdiv`.
- R4: Word 1 (byte offset 0x04) holds post-divider 2 in bits 14:12, post-divider 1 in bits 10:8 and the 6-bit reference divider in bits 5:0.
- R5: A write to word 2 (byte offset 0x08) loads write-data bits 23:0 into the fraction whatever the upper bits hold. Write-data bits 31:24 change nothing.
- R6: Word 3 (byte offset 0x0C) holds the work mode in bits 9:8 (0 slow, 1 normal, 2 deep slow) and the integer-mode select in bit 3.
- R7: Bit 31 of word 2 reads the lock input delayed by two clock edges of synchronization. Writes never alter it.
- R8: Read data is combinational for the addressed word. Unimplemented bits read 0, and bits 31:16 of words 0, 1 and 3 read 0.
- R9: With `bus_we` low, no stored field changes, whatever the address and write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Word address (byte-offset bits 3:2) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; bits 31:16 act as the bit mask for masked words |
| bus_rdata | output | 32 | Read data of the addressed word |
| pll_lock_in | input | 1 | Asynchronous lock indication from the PLL |
| cfg_fbdiv | output | 12 | Feedback divider |
| cfg_refdiv | output | 6 | Reference divider |
| cfg_postdiv1 | output | 3 | Post-divider 1 |
| cfg_postdiv2 | output | 3 | Post-divider 2 |
| cfg_frac | output | 24 | Fractional divider |
| cfg_mode | output | 2 | Work mode |
| cfg_int_mode | output | 1 | Integer-mode select |

## Verification
The hardest case to reach is a masked write whose mask only partly covers a field that already holds a non-zero value. Only there does a design that ignores the mask, or clears unmasked bits, give a wrong answer. The stimulus first loads every field with a known pattern. It then issues writes whose masks and data bits disagree in alternating nibbles, followed by a long run of random masks over random data. A reference model checks every field on every cycle. The lock flag is toggled while the fraction word is written with bit 31 set, which shows that writes cannot reach the flag.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int REG_W  = 32;
  localparam int HALF_W = 16;

  localparam int WORD_FB   = 0;
  localparam int WORD_DIV  = 1;
  localparam int WORD_FRAC = 2;
  localparam int WORD_MODE = 3;
  localparam int NUM_WORDS = 4;

  localparam int FB_W   = 12;
  localparam int REF_W  = 6;
  localparam int PD_W   = 3;
  localparam int FRAC_W = 24;
  localparam int MODE_W = 2;

  localparam int PD2_LSB  = 12;
  localparam int PD1_LSB  = 8;
  localparam int MODE_LSB = 8;
  localparam int INT_BIT  = 3;
  localparam int LOCK_BIT = 31;

  localparam logic [HALF_W-1:0] IMPL_FB   = 16'h0FFF;
  localparam logic [HALF_W-1:0] IMPL_DIV  = 16'h773F;
  localparam logic [HALF_W-1:0] IMPL_MODE = 16'h0308;

  typedef enum logic [MODE_W-1:0] {
    MODE_SLOW      = 2'd0,
    MODE_NORMAL    = 2'd1,
    MODE_DEEP_SLOW = 2'd2
  } work_mode_e;

  localparam logic [HALF_W-1:0] RST_MODE_WORD =
    HALF_W'({MODE_SLOW}) << MODE_LSB;
endpackage

// File: rtl/pll_masked_half.sv
module pll_masked_half #(
  parameter int                DATA_W = 32,
  parameter logic [DATA_W/2-1:0] IMPL = '1,
  parameter logic [DATA_W/2-1:0] RST  = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [DATA_W-1:0]     wr_word,
  output logic [DATA_W/2-1:0]   q
);
  localparam int HW = DATA_W / 2;

  logic [HW-1:0] bit_en;
  logic [HW-1:0] nxt;

  assign bit_en = wr_word[DATA_W-1:HW];

  always_comb begin
    nxt = ((q & ~bit_en) | (wr_word[HW-1:0] & bit_en)) & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST & IMPL;
    else if (wr_en) q <= nxt;
  end

  // R2: unmasked bits keep their value across a write
  assert_masked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((q ^ $past(q)) & ~$past(bit_en)) == '0));

  // R2: masked implemented bits follow the written data
  assert_masked_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((q ^ $past(wr_word[HW-1:0])) & $past(bit_en) & IMPL) == '0));

  // R9: no strobe, no change
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];

  // R7: the status bit advances one stage per clock
  assert_lock_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out == $past(chain[STAGES-2]));
endmodule

// File: rtl/pll_cfg_bank.sv
module pll_cfg_bank
  import pll_cfg_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:2] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              pll_lock_in,
  output logic [FB_W-1:0]   cfg_fbdiv,
  output logic [REF_W-1:0]  cfg_refdiv,
  output logic [PD_W-1:0]   cfg_postdiv1,
  output logic [PD_W-1:0]   cfg_postdiv2,
  output logic [FRAC_W-1:0] cfg_frac,
  output logic [MODE_W-1:0] cfg_mode,
  output logic              cfg_int_mode
);
  localparam int WA_W = ADDR_W - 2;

  logic [NUM_WORDS-1:0] word_we;
  logic [HALF_W-1:0]    fb_q, div_q, mode_q;
  logic [FRAC_W-1:0]    frac_q;
  logic                 lock_q;

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_dec
    assign word_we[k] = bus_we && (bus_addr == WA_W'(k));
  end

  pll_masked_half #(.DATA_W(REG_W), .IMPL(IMPL_FB), .RST('0)) u_fb (
    .clk(clk), .rst_n(rst_n), .wr_en(word_we[WORD_FB]),
    .wr_word(bus_wdata), .q(fb_q));

  pll_masked_half #(.DATA_W(REG_W), .IMPL(IMPL_DIV), .RST('0)) u_div (
    .clk(clk), .rst_n(rst_n), .wr_en(word_we[WORD_DIV]),
    .wr_word(bus_wdata), .q(div_q));

  pll_masked_half #(.DATA_W(REG_W), .IMPL(IMPL_MODE), .RST(RST_MODE_WORD)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(word_we[WORD_MODE]),
    .wr_word(bus_wdata), .q(mode_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  frac_q <= '0;
    else if (word_we[WORD_FRAC]) frac_q <= bus_wdata[FRAC_W-1:0];
  end

  pll_lock_sync #(.STAGES(SYNC_STAGES)) u_lock (
    .clk(clk), .rst_n(rst_n), .async_in(pll_lock_in), .sync_out(lock_q));

  assign cfg_fbdiv    = fb_q[FB_W-1:0];
  assign cfg_refdiv   = div_q[REF_W-1:0];
  assign cfg_postdiv1 = div_q[PD1_LSB +: PD_W];
  assign cfg_postdiv2 = div_q[PD2_LSB +: PD_W];
  assign cfg_frac     = frac_q;
  assign cfg_mode     = mode_q[MODE_LSB +: MODE_W];
  assign cfg_int_mode = mode_q[INT_BIT];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == WA_W'(WORD_FB))   bus_rdata[HALF_W-1:0] = fb_q;
    if (bus_addr == WA_W'(WORD_DIV))  bus_rdata[HALF_W-1:0] = div_q;
    if (bus_addr == WA_W'(WORD_MODE)) bus_rdata[HALF_W-1:0] = mode_q;
    if (bus_addr == WA_W'(WORD_FRAC)) begin
      bus_rdata[FRAC_W-1:0] = frac_q;
      bus_rdata[LOCK_BIT]   = lock_q;
    end
  end

  // R5: a fraction write takes the low 24 data bits
  assert_frac_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_we[WORD_FRAC] |=> (cfg_frac == $past(bus_wdata[FRAC_W-1:0])));

  // R8: masked words never return data in their upper halfword
  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != WA_W'(WORD_FRAC)) |-> (bus_rdata[REG_W-1:HALF_W] == '0));

  // R7: the lock flag does not move with a bus write alone
  assert_lock_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_we[WORD_FRAC] && $stable(pll_lock_in) && ($past(pll_lock_in) == lock_q))
      |=> $stable(lock_q));
endmodule

// File: tb/pll_cfg_bank_tb.sv
module pll_cfg_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:2]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pll_lock_in = 1'b0;
  logic [11:0] cfg_fbdiv;
  logic [5:0]  cfg_refdiv;
  logic [2:0]  cfg_postdiv1, cfg_postdiv2;
  logic [23:0] cfg_frac;
  logic [1:0]  cfg_mode;
  logic        cfg_int_mode;

  int n_checks = 0;
  int n_errors = 0;
  string phase = "R1";

  // reference model state
  logic [15:0] m_w0 = '0, m_w1 = '0, m_w3 = '0;
  logic [23:0] m_frac = '0;
  logic [1:0]  m_sync = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_cfg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_lock_in(pll_lock_in),
    .cfg_fbdiv(cfg_fbdiv), .cfg_refdiv(cfg_refdiv), .cfg_postdiv1(cfg_postdiv1),
    .cfg_postdiv2(cfg_postdiv2), .cfg_frac(cfg_frac), .cfg_mode(cfg_mode),
    .cfg_int_mode(cfg_int_mode));

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s/%s %s: actual=%h expected=%h", phase, tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mwrite(input logic [15:0] cur,
                                         input logic [31:0] d,
                                         input logic [15:0] impl);
    return ((cur & ~d[31:16]) | (d[15:0] & d[31:16])) & impl;
  endfunction

  task automatic compare();
    logic [31:0] exp_rd;
    case (bus_addr)
      2'd0:    exp_rd = {16'h0, m_w0};
      2'd1:    exp_rd = {16'h0, m_w1};
      2'd2:    exp_rd = {m_sync[1], 7'h0, m_frac};
      default: exp_rd = {16'h0, m_w3};
    endcase
    chk("R3", "fbdiv",    32'(cfg_fbdiv),    32'(m_w0[11:0]));
    chk("R4", "refdiv",   32'(cfg_refdiv),   32'(m_w1[5:0]));
    chk("R4", "postdiv1", 32'(cfg_postdiv1), 32'(m_w1[10:8]));
    chk("R4", "postdiv2", 32'(cfg_postdiv2), 32'(m_w1[14:12]));
    chk("R5", "frac",     32'(cfg_frac),     32'(m_frac));
    chk("R6", "mode",     32'(cfg_mode),     32'(m_w3[9:8]));
    chk("R6", "intmode",  32'(cfg_int_mode), 32'(m_w3[3]));
    chk("R8", "rdata",    bus_rdata,         exp_rd);
  endtask

  task automatic step(input logic [1:0] a, input logic we,
                      input logic [31:0] d, input logic lk);
    bus_addr = a; bus_we = we; bus_wdata = d; pll_lock_in = lk;
    @(posedge clk);
    if (!rst_n) begin
      m_w0 = '0; m_w1 = '0; m_w3 = '0; m_frac = '0; m_sync = '0;
    end else begin
      if (we) begin
        case (a)
          2'd0:    m_w0 = mwrite(m_w0, d, 16'h0FFF);
          2'd1:    m_w1 = mwrite(m_w1, d, 16'h773F);
          2'd2:    m_frac = d[23:0];
          default: m_w3 = mwrite(m_w3, d, 16'h0308);
        endcase
      end
      m_sync = {m_sync[0], lk};
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    // R1: reset state, with bus activity and lock high held off
    for (int i = 0; i < 4; i++) step(2'(i), 1'b1, 32'hFFFF_FFFF, 1'b1);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(2'(i), 1'b0, 32'h0, 1'b0);

    phase = "R3";
    step(2'd0, 1'b1, 32'hFFFF_0ABC, 1'b0);
    step(2'd0, 1'b1, 32'hFFFF_F123, 1'b0);

    phase = "R2";
    step(2'd0, 1'b1, 32'h00F0_0F0F, 1'b0);
    step(2'd0, 1'b1, 32'h0F0F_F0F0, 1'b0);
    step(2'd0, 1'b1, 32'h0000_FFFF, 1'b0);
    step(2'd3, 1'b1, 32'hFFFF_FFFF, 1'b0);
    step(2'd3, 1'b1, 32'h0100_0000, 1'b0);
    step(2'd1, 1'b1, 32'hAAAA_FFFF, 1'b0);
    step(2'd1, 1'b1, 32'h5555_0000, 1'b0);

    phase = "R4";
    step(2'd1, 1'b1, 32'hFFFF_FFFF, 1'b0);
    step(2'd1, 1'b1, 32'hFFFF_2105, 1'b0);
    step(2'd1, 1'b1, 32'h7000_5000, 1'b0);

    phase = "R5";
    step(2'd2, 1'b1, 32'hFFAB_CDEF, 1'b0);
    step(2'd2, 1'b1, 32'h0012_3456, 1'b0);
    step(2'd2, 1'b1, 32'h8000_0000, 1'b0);

    phase = "R6";
    step(2'd3, 1'b1, 32'h0300_0100, 1'b0);
    step(2'd3, 1'b1, 32'h0008_0008, 1'b0);
    step(2'd3, 1'b1, 32'h0300_0200, 1'b0);
    step(2'd3, 1'b1, 32'h0308_0000, 1'b0);

    phase = "R7";
    step(2'd2, 1'b0, 32'h0, 1'b1);
    step(2'd2, 1'b0, 32'h0, 1'b1);
    step(2'd2, 1'b1, 32'h0000_0000, 1'b1);
    step(2'd2, 1'b1, 32'h0000_0000, 1'b0);
    step(2'd2, 1'b1, 32'hFFFF_FFFF, 1'b0);
    step(2'd2, 1'b1, 32'hFFFF_FFFF, 1'b0);
    step(2'd2, 1'b0, 32'h0, 1'b1);

    phase = "R9";
    for (int i = 0; i < 8; i++) step(2'(i), 1'b0, 32'hFFFF_FFFF, 1'b0);
    for (int i = 0; i < 8; i++) step(2'(i), 1'b0, 32'h0000_0000, 1'b1);

    phase = "R8";
    for (int i = 0; i < 200; i++)
      step(2'($urandom_range(0, 3)), 1'b0, $urandom, 1'($urandom_range(0, 1)));

    phase = "R2";
    for (int i = 0; i < 3000; i++)
      step(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), $urandom,
           1'($urandom_range(0, 1)));

    phase = "R1";
    rst_n = 1'b0;
    step(2'd2, 1'b0, 32'h0, 1'b1);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(2'(i), 1'b0, 32'h0, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule